// File: doc/BRIEF.md
# Segmented Memory Address Extension Unit

This unit widens 16-bit logical addresses from a processor core and a DMA engine into a 22-bit physical address. It does this by placing a 6-bit segment number above the logical address, which divides the 4 Mbyte space into 64 Kbyte segments. Three segment registers are held: one for program code, one for interrupt service, and one for DMA. For every cycle the unit picks which of them drives the upper address bits. The choice depends on whether a DMA cycle is granted, whether a service routine is running, and which interrupt mode is set.

The unit also sequences the stack frame for interrupt entry and return. It drives one word per cycle toward an external stack memory. A control bit selects between two interrupt modes:

- **Compatibility mode.** The frame holds only the return address and the flags. The interrupt segment register replaces the code segment register for the whole routine.
- **Extended mode.** The code segment register is added to the frame and then reloaded from the interrupt segment register. It is restored from the stack on return. This costs one extra cycle at entry and one extra cycle at return.

Writes to the code segment register are accepted only while that register is not steering fetch. A refused write sets a sticky error flag.

Top module: `seg_xlate`

## Requirements
- R1: After reset, all three segment registers and the mode register read as 0, and `busy`, `seg_err` and `ret_done` are 0.
- R2: When no DMA cycle is granted, `phys_addr` is {code segment, `log_addr`}. Inside a compatibility-mode service routine it is instead {interrupt segment, `log_addr`}.
- R3: While `dma_req` is 1, the segment comes from the interrupt segment register if `dma_ps` is 0, and from the DMA segment register if `dma_ps` is 1. `dma_ps` has no effect while `dma_req` is 0.
- R4: Compatibility-mode entry starts on the cycle after the accepted `irq_enter`. It then pushes exactly 3 words, one per cycle, in this order: PC low byte, PC high byte, flags. The code segment register is left unchanged.
- R5: Extended-mode entry pushes exactly 4 words: PC low byte, PC high byte, flags, then the code segment register zero-extended to 8 bits. After the last push, the code segment register holds the interrupt segment value.
- R6: A compatibility-mode return pops exactly 3 words: flags, PC high byte, PC low byte. In the cycle after the last pop, `ret_done` is 1 for one cycle, and `ret_pc` and `ret_flags` hold the popped values.
- R7: An extended-mode return pops exactly 4 words. The first is the code segment word, and it is loaded into the code segment register. It is followed by flags, PC high byte and PC low byte.
- R8: A write to the code segment register takes effect only inside a compatibility-mode service routine. Any other such write is dropped and sets `seg_err`. `seg_err` stays 1 until `err_clr` is pulsed.
- R9: `cfg_sel` encodes the registers as follows: 0 is the code segment register, 1 the interrupt segment register, 2 the DMA segment register, and 3 the mode register. `cfg_rdata` returns the selected register. Only bit 6 of the mode register is stored, and 1 selects extended mode.
- R10: `irq_enter` and `irq_return` are ignored while `busy` is 1.
- R11: A code segment write accepted inside a compatibility-mode routine is visible at once through `cfg_rdata`. It steers fetch only after the return completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R9) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| err_clr | input | 1 | Clears the sticky write error |
| seg_err | output | 1 | Sticky flag for a refused code segment write |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_pc | input | 16 | Return address to save |
| irq_flags | input | 8 | Flags to save |
| irq_return | input | 1 | Interrupt return strobe |
| ret_done | output | 1 | One-cycle pulse when the return frame is popped |
| ret_pc | output | 16 | Restored return address |
| ret_flags | output | 8 | Restored flags |
| stk_push | output | 1 | Stack push request |
| stk_pop | output | 1 | Stack pop request |
| stk_wdata | output | 8 | Word to push |
| stk_rdata | input | 8 | Popped word, valid while `stk_pop` is 1 |
| busy | output | 1 | Frame sequence in progress |
| dma_req | input | 1 | DMA cycle granted |
| dma_ps | input | 1 | DMA segment select |
| log_addr | input | 16 | Logical address |
| phys_addr | output | 22 | Physical address |

## Verification
The hardest state to reach is a code segment register that differs from the segment steering fetch. Reset leaves the code segment at 0, and outside a compatibility-mode routine every write to it is refused. The bench therefore enters a compatibility-mode routine, writes a new code segment there, and checks that fetch still uses the interrupt segment. It then returns and checks that the new value takes over. For the extended-mode restore, the bench feeds back a segment word that differs from the one pushed, which shows that the restored value comes from the stack. It also raises both strobes in the middle of a frame to confirm they are ignored.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      SEL_CODE = 2'd0,
      SEL_INTR = 2'd1,
      SEL_DMA  = 2'd2,
      SEL_MODE = 2'd3
   } cfg_sel_e;

   localparam int MODE_BIT = 6;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PUSH = 2'd1,
      SQ_POP  = 2'd2
   } sq_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_pkg::*;
#(
   parameter int SEG_W  = 6,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              err_clr,
   input  logic              code_free,
   input  logic              seq_ld,
   input  logic [SEG_W-1:0]  seq_ld_val,
   output logic [SEG_W-1:0]  csr_q,
   output logic [SEG_W-1:0]  isr_q,
   output logic [SEG_W-1:0]  dsr_q,
   output logic              mode_q,
   output logic              err_q,
   output logic [WORD_W-1:0] rd_data
);
   logic wr_code, wr_intr, wr_dma, wr_mode, wr_refused;
   logic unused_wdata;

   assign wr_code    = cfg_we && (cfg_sel == SEL_CODE);
   assign wr_intr    = cfg_we && (cfg_sel == SEL_INTR);
   assign wr_dma     = cfg_we && (cfg_sel == SEL_DMA);
   assign wr_mode    = cfg_we && (cfg_sel == SEL_MODE);
   assign wr_refused = wr_code && !code_free;
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q  <= '0;
         isr_q  <= '0;
         dsr_q  <= '0;
         mode_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (seq_ld)
            csr_q <= seq_ld_val;
         else if (wr_code && code_free)
            csr_q <= cfg_wdata[SEG_W-1:0];
         if (wr_intr) isr_q  <= cfg_wdata[SEG_W-1:0];
         if (wr_dma)  dsr_q  <= cfg_wdata[SEG_W-1:0];
         if (wr_mode) mode_q <= cfg_wdata[MODE_BIT];
         if (wr_refused)
            err_q <= 1'b1;
         else if (err_clr)
            err_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (cfg_sel)
         SEL_CODE: rd_data = WORD_W'(csr_q);
         SEL_INTR: rd_data = WORD_W'(isr_q);
         SEL_DMA:  rd_data = WORD_W'(dsr_q);
         default:  rd_data = WORD_W'(mode_q) << MODE_BIT;
      endcase
   end
endmodule

// File: rtl/seg_frame_seq.sv
module seg_frame_seq
   import seg_pkg::*;
#(
   parameter int SEG_W   = 6,
   parameter int LADDR_W = 16,
   parameter int WORD_W  = 8,
   parameter int NEST_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode,
   input  logic               irq_enter,
   input  logic [LADDR_W-1:0] irq_pc,
   input  logic [WORD_W-1:0]  irq_flags,
   input  logic               irq_return,
   input  logic [SEG_W-1:0]   csr,
   input  logic [SEG_W-1:0]   isr,
   output logic               stk_push,
   output logic               stk_pop,
   output logic [WORD_W-1:0]  stk_wdata,
   input  logic [WORD_W-1:0]  stk_rdata,
   output logic               ret_done,
   output logic [LADDR_W-1:0] ret_pc,
   output logic [WORD_W-1:0]  ret_flags,
   output logic               busy,
   output logic               code_free,
   output logic               seq_ld,
   output logic [SEG_W-1:0]   seq_ld_val
);
   localparam int PC_WORDS  = LADDR_W / WORD_W;
   localparam int FRAME_MAX = PC_WORDS + 2;
   localparam int IDX_W     = $clog2(FRAME_MAX);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(PC_WORDS);
   localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(PC_WORDS + 1);

   sq_e                state;
   logic [IDX_W-1:0]   idx, last, pos;
   logic               mode_q, done_q, at_end;
   logic               take_enter, take_return;
   logic [LADDR_W-1:0] pc_q;
   logic [WORD_W-1:0]  flags_q;
   logic [NEST_W-1:0]  nest_q;
   logic [WORD_W-1:0]  frame_w [FRAME_MAX];

   generate
      for (genvar k = 0; k < PC_WORDS; k++) begin : g_pcw
         assign frame_w[k] = pc_q[k*WORD_W +: WORD_W];
      end
   endgenerate
   assign frame_w[PC_WORDS]     = flags_q;
   assign frame_w[PC_WORDS + 1] = WORD_W'(csr);

   assign at_end      = (idx == last);
   assign pos         = last - idx;
   assign take_enter  = (state == SQ_IDLE) && irq_enter && !(!mode && (&nest_q));
   assign take_return = (state == SQ_IDLE) && irq_return && !take_enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         idx     <= '0;
         last    <= '0;
         mode_q  <= 1'b0;
         done_q  <= 1'b0;
         pc_q    <= '0;
         flags_q <= '0;
         nest_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               idx <= '0;
               if (take_enter) begin
                  state   <= SQ_PUSH;
                  mode_q  <= mode;
                  last    <= mode ? LAST_LONG : LAST_SHORT;
                  pc_q    <= irq_pc;
                  flags_q <= irq_flags;
               end else if (take_return) begin
                  state  <= SQ_POP;
                  mode_q <= mode;
                  last   <= mode ? LAST_LONG : LAST_SHORT;
               end
            end
            SQ_PUSH: begin
               if (at_end) begin
                  state <= SQ_IDLE;
                  if (!mode_q) nest_q <= nest_q + 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SQ_POP: begin
               for (int b = 0; b < PC_WORDS; b++)
                  if (pos == IDX_W'(b)) pc_q[b*WORD_W +: WORD_W] <= stk_rdata;
               if (pos == LAST_SHORT) flags_q <= stk_rdata;
               if (at_end) begin
                  state  <= SQ_IDLE;
                  done_q <= 1'b1;
                  if (!mode_q && (nest_q != '0)) nest_q <= nest_q - 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign stk_push  = (state == SQ_PUSH);
   assign stk_pop   = (state == SQ_POP);
   assign stk_wdata = stk_push ? frame_w[idx] : '0;
   assign busy      = (state != SQ_IDLE);
   assign code_free = (nest_q != '0);
   assign ret_done  = done_q;
   assign ret_pc    = pc_q;
   assign ret_flags = flags_q;

   always_comb begin
      seq_ld     = 1'b0;
      seq_ld_val = isr;
      if (stk_push && at_end && mode_q) begin
         seq_ld = 1'b1;
      end else if (stk_pop && mode_q && (pos == LAST_LONG)) begin
         seq_ld     = 1'b1;
         seq_ld_val = stk_rdata[SEG_W-1:0];
      end
   end
endmodule

// File: rtl/seg_addr_sel.sv
module seg_addr_sel #(
   parameter int SEG_W   = 6,
   parameter int LADDR_W = 16
) (
   input  logic [SEG_W-1:0]         csr,
   input  logic [SEG_W-1:0]         isr,
   input  logic [SEG_W-1:0]         dsr,
   input  logic                     in_isr,
   input  logic                     dma_req,
   input  logic                     dma_ps,
   input  logic [LADDR_W-1:0]       log_addr,
   output logic [SEG_W+LADDR_W-1:0] phys_addr
);
   logic [SEG_W-1:0] seg;

   always_comb begin
      if (dma_req)
         seg = dma_ps ? dsr : isr;
      else
         seg = in_isr ? isr : csr;
   end

   assign phys_addr = {seg, log_addr};
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_pkg::*;
#(
   parameter int SEG_W   = 6,
   parameter int LADDR_W = 16,
   parameter int WORD_W  = 8,
   parameter int NEST_W  = 3,
   localparam int PADDR_W = SEG_W + LADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [WORD_W-1:0]  cfg_wdata,
   output logic [WORD_W-1:0]  cfg_rdata,
   input  logic               err_clr,
   output logic               seg_err,
   input  logic               irq_enter,
   input  logic [LADDR_W-1:0] irq_pc,
   input  logic [WORD_W-1:0]  irq_flags,
   input  logic               irq_return,
   output logic               ret_done,
   output logic [LADDR_W-1:0] ret_pc,
   output logic [WORD_W-1:0]  ret_flags,
   output logic               stk_push,
   output logic               stk_pop,
   output logic [WORD_W-1:0]  stk_wdata,
   input  logic [WORD_W-1:0]  stk_rdata,
   output logic               busy,
   input  logic               dma_req,
   input  logic               dma_ps,
   input  logic [LADDR_W-1:0] log_addr,
   output logic [PADDR_W-1:0] phys_addr
);
   generate
      if (LADDR_W % WORD_W != 0) begin : g_bad_word
         $error("LADDR_W must be a multiple of WORD_W");
      end
      if (SEG_W > WORD_W || MODE_BIT >= WORD_W) begin : g_bad_seg
         $error("segment and mode fields must fit in one word");
      end
      if (NEST_W < 1) begin : g_bad_nest
         $error("NEST_W must be at least 1");
      end
   endgenerate

   logic [SEG_W-1:0] csr_q, isr_q, dsr_q, seq_ld_val;
   logic             mode_q, code_free, seq_ld;

   seg_regfile #(.SEG_W(SEG_W), .WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .err_clr(err_clr), .code_free(code_free),
      .seq_ld(seq_ld), .seq_ld_val(seq_ld_val), .csr_q(csr_q),
      .isr_q(isr_q), .dsr_q(dsr_q), .mode_q(mode_q), .err_q(seg_err),
      .rd_data(cfg_rdata)
   );

   seg_frame_seq #(.SEG_W(SEG_W), .LADDR_W(LADDR_W), .WORD_W(WORD_W),
                   .NEST_W(NEST_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .irq_enter(irq_enter),
      .irq_pc(irq_pc), .irq_flags(irq_flags), .irq_return(irq_return),
      .csr(csr_q), .isr(isr_q), .stk_push(stk_push), .stk_pop(stk_pop),
      .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .ret_done(ret_done),
      .ret_pc(ret_pc), .ret_flags(ret_flags), .busy(busy),
      .code_free(code_free), .seq_ld(seq_ld), .seq_ld_val(seq_ld_val)
   );

   seg_addr_sel #(.SEG_W(SEG_W), .LADDR_W(LADDR_W)) u_addr (
      .csr(csr_q), .isr(isr_q), .dsr(dsr_q), .in_isr(code_free),
      .dma_req(dma_req), .dma_ps(dma_ps), .log_addr(log_addr),
      .phys_addr(phys_addr)
   );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [1:0]       cfg_sel,
   input logic             err_clr,
   input logic             seg_err,
   input logic             code_free,
   input logic             seq_ld,
   input logic [SEG_W-1:0] csr,
   input logic [SEG_W-1:0] isr,
   input logic             stk_push,
   input logic             stk_pop,
   input logic             irq_enter,
   input logic             ret_done
);
   // R8: a refused code segment write leaves the register and raises the flag
   a_r8_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd0 && !code_free && !seq_ld) |=> ($stable(csr) && seg_err));

   // R8: the error flag holds until cleared
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_err && !err_clr) |=> seg_err);

   // R5: after the last extended-mode push the code segment equals the interrupt segment
   a_r5_csr_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(seq_ld) && $past(stk_push)) |-> (csr == $past(isr)));

   // R4: a push run only starts after an entry strobe
   a_r4_push_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stk_push) |-> $past(irq_enter));

   // R6: completion follows a pop cycle
   a_r6_done_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |-> $past(stk_pop));
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
   .err_clr(err_clr), .seg_err(seg_err), .code_free(code_free),
   .seq_ld(seq_ld), .csr(csr_q), .isr(isr_q), .stk_push(stk_push),
   .stk_pop(stk_pop), .irq_enter(irq_enter), .ret_done(ret_done)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, err_clr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [7:0]  cfg_wdata = 8'h00, cfg_rdata;
   logic        seg_err, irq_enter = 1'b0, irq_return = 1'b0, ret_done;
   logic [15:0] irq_pc = 16'h0, ret_pc, log_addr = 16'h0;
   logic [7:0]  irq_flags = 8'h0, ret_flags, stk_wdata, stk_rdata = 8'h0;
   logic        stk_push, stk_pop, busy, dma_req = 1'b0, dma_ps = 1'b0;
   logic [21:0] phys_addr;

   int   n_chk = 0, n_bad = 0, n;
   logic [7:0] pw [4];
   logic [7:0] img [4];

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_clr(err_clr),
      .seg_err(seg_err), .irq_enter(irq_enter), .irq_pc(irq_pc),
      .irq_flags(irq_flags), .irq_return(irq_return), .ret_done(ret_done),
      .ret_pc(ret_pc), .ret_flags(ret_flags), .stk_push(stk_push),
      .stk_pop(stk_pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
      .busy(busy), .dma_req(dma_req), .dma_ps(dma_ps), .log_addr(log_addr),
      .phys_addr(phys_addr)
   );

   always #10 clk = ~clk;

   // {dma_req, dma_ps, log_addr, expected phys} with code=00, intr=2A, dma=13
   localparam logic [39:0] VEC [7] = '{
      {1'b0, 1'b0, 16'h1234, 22'h001234},
      {1'b0, 1'b0, 16'hFFFF, 22'h00FFFF},
      {1'b1, 1'b0, 16'h0000, 22'h2A0000},
      {1'b1, 1'b0, 16'hABCD, 22'h2AABCD},
      {1'b1, 1'b1, 16'h5555, 22'h135555},
      {1'b1, 1'b1, 16'hFFFF, 22'h13FFFF},
      {1'b0, 1'b1, 16'h0042, 22'h000042}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
      cfg_sel = sel; #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic clear_err();
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic do_enter(input logic [15:0] pc, input logic [7:0] fl, input bit poke,
                           output int cnt);
      cnt = 0;
      irq_pc = pc; irq_flags = fl; irq_enter = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_enter = 1'b0;
      while (busy && cnt < 8) begin
         if (stk_push) begin pw[cnt] = stk_wdata; cnt++; end
         if (poke && cnt == 2) begin irq_enter = 1'b1; irq_return = 1'b1; end
         else begin irq_enter = 1'b0; irq_return = 1'b0; end
         @(posedge clk); @(negedge clk);
      end
      irq_enter = 1'b0; irq_return = 1'b0;
   endtask

   task automatic do_return(input int len, output int cnt);
      cnt = 0;
      irq_return = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_return = 1'b0;
      while (busy && cnt < 8) begin
         if (stk_pop) begin stk_rdata = img[len-1-cnt]; cnt++; end
         @(posedge clk); @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, 8'h00, "R1 code seg");
      rd(2'd1, 8'h00, "R1 intr seg");
      rd(2'd2, 8'h00, "R1 dma seg");
      rd(2'd3, 8'h00, "R1 mode");
      chk("R1 busy", busy, 0);
      chk("R1 seg_err", seg_err, 0);
      chk("R1 ret_done", ret_done, 0);

      // R8 write outside a routine is refused and sticky
      wr(2'd0, 8'h09);
      chk("R8 refused sets err", seg_err, 1);
      rd(2'd0, 8'h00, "R8 refused write ignored");
      @(negedge clk);
      chk("R8 err sticky", seg_err, 1);
      clear_err();
      chk("R8 err cleared", seg_err, 0);

      // R9 register map and mode bit
      wr(2'd1, 8'h2A);
      wr(2'd2, 8'h13);
      rd(2'd1, 8'h2A, "R9 intr seg readback");
      rd(2'd2, 8'h13, "R9 dma seg readback");
      wr(2'd3, 8'hFF);
      rd(2'd3, 8'h40, "R9 only bit 6 kept");
      wr(2'd3, 8'h00);
      rd(2'd3, 8'h00, "R9 mode cleared");

      // R2 / R3 vector walk
      foreach (VEC[i]) begin
         dma_req = VEC[i][39]; dma_ps = VEC[i][38]; log_addr = VEC[i][37:22];
         #1;
         chk($sformatf("R2 R3 vector %0d", i), phys_addr, VEC[i][21:0]);
      end
      dma_req = 1'b0; dma_ps = 1'b0; log_addr = 16'h1234;

      // R4 compatibility entry
      do_enter(16'hBEEF, 8'h5A, 1'b0, n);
      chk("R4 push count", n, 3);
      chk("R4 word0 pc low", pw[0], 8'hEF);
      chk("R4 word1 pc high", pw[1], 8'hBE);
      chk("R4 word2 flags", pw[2], 8'h5A);
      rd(2'd0, 8'h00, "R4 code seg unchanged");
      chk("R2 fetch uses intr seg", phys_addr, 22'h2A1234);

      // R11 segment change inside compatibility routine
      wr(2'd0, 8'h07);
      chk("R8 write accepted no err", seg_err, 0);
      rd(2'd0, 8'h07, "R11 readback new code seg");
      chk("R11 fetch still intr seg", phys_addr, 22'h2A1234);
      dma_req = 1'b1; dma_ps = 1'b1; #1;
      chk("R3 dma seg inside routine", phys_addr, 22'h131234);
      dma_req = 1'b0; dma_ps = 1'b0;

      // R6 compatibility return
      img = pw;
      do_return(3, n);
      chk("R6 pop count", n, 3);
      chk("R6 ret_done", ret_done, 1);
      chk("R6 ret_pc", ret_pc, 16'hBEEF);
      chk("R6 ret_flags", ret_flags, 8'h5A);
      chk("R11 fetch uses new code seg", phys_addr, 22'h071234);
      @(negedge clk);
      chk("R6 ret_done one cycle", ret_done, 0);

      // R5 extended entry with strobes raised mid-frame (R10)
      wr(2'd3, 8'h40);
      do_enter(16'h1357, 8'hC3, 1'b1, n);
      chk("R5 R10 push count", n, 4);
      chk("R5 word0 pc low", pw[0], 8'h57);
      chk("R5 word1 pc high", pw[1], 8'h13);
      chk("R5 word2 flags", pw[2], 8'hC3);
      chk("R5 word3 code seg", pw[3], 8'h07);
      rd(2'd0, 8'h2A, "R5 code seg reloaded");
      chk("R5 fetch address", phys_addr, 22'h2A1234);
      chk("R10 no return started", busy, 0);
      chk("R10 no ret_done", ret_done, 0);

      // R8 refused in extended routine
      wr(2'd0, 8'h15);
      chk("R8 refused in extended mode", seg_err, 1);
      rd(2'd0, 8'h2A, "R8 code seg kept");
      clear_err();

      // R7 extended return restores from stack
      img = pw;
      img[3] = 8'h3C;
      do_return(4, n);
      chk("R7 pop count", n, 4);
      chk("R7 ret_pc", ret_pc, 16'h1357);
      chk("R7 ret_flags", ret_flags, 8'hC3);
      rd(2'd0, 8'h3C, "R7 code seg restored");
      chk("R7 fetch address", phys_addr, 22'h3C1234);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule